// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Store Controller

This block connects a small processor's I/O register port to a byte-addressable non-volatile data store, held here as an internal array with one entry per address. Software loads an address register and a data register, then fires a read or a write strobe. A read copies the addressed byte into the data register. A write is self-timed: it captures the address and the data, runs a countdown, and commits the byte to the store when the countdown expires.

Each accepted access raises a stall output that freezes the processor pipeline for a fixed number of cycles. Reads stall longer than the start of a write. A busy output stays high for the whole write, so software can poll it before it issues the next byte. The block also takes a power-down request. It keeps its clock request asserted while a write is still running. If power-down arrived during a write, it keeps the clock request asserted after the write finishes until the request is withdrawn.

Top module: `nvm_byte_ctrl`

## Requirements
- R1: After reset, busy_o and stall_o are 0, data_o is 0 and clk_req_o is 1 while pd_req_i is low.
- R2: When the block is idle (busy_o and stall_o both low), a read strobe raises stall_o for exactly RD_STALL (4) cycles, starting in the cycle after the strobe edge. When stall_o falls, data_o holds the byte stored at the address register.
- R3: When the block is idle, a write strobe raises stall_o for exactly WR_STALL (2) cycles, starting in the cycle after the strobe edge.
- R4: An accepted write holds busy_o high for exactly WRITE_CYCLES cycles. The byte is in the store from the cycle busy_o falls.
- R5: A write stores the address and data that were held in the registers at the strobe edge. Writes to those registers while busy_o is high do not change the stored byte.
- R6: A read or write strobe while busy_o is high is ignored. It raises no stall, leaves data_o unchanged and leaves the store unchanged.
- R7: If read and write strobes arrive together on an idle block, the write is accepted and the read is dropped. data_o keeps the written data value.
- R8: clk_req_o is 1 whenever pd_req_i is low. With pd_req_i high, no access running and no write overlapping the current request, clk_req_o is 0.
- R9: A write keeps counting and commits normally while pd_req_i is high, and clk_req_o stays 1 for as long as busy_o is high.
- R10: If pd_req_i is high at any time during a write, clk_req_o stays 1 after that write completes until pd_req_i goes low.
- R11: Reset leaves the store contents intact.
- R12: The address is 12 bits wide, with 4096 distinct byte locations. Each location keeps its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_we_i | input | 1 | Load address register |
| addr_i | input | ADDR_W | Address register input |
| data_we_i | input | 1 | Load data register |
| data_i | input | DATA_W | Data register input |
| rd_req_i | input | 1 | Read strobe |
| wr_req_i | input | 1 | Write strobe |
| pd_req_i | input | 1 | Power-down request |
| data_o | output | DATA_W | Data register readback |
| busy_o | output | 1 | Self-timed write in progress |
| stall_o | output | 1 | Processor pipeline hold |
| clk_req_o | output | 1 | Oscillator keep-alive request |

## Verification
The assertions assume that the register-load and strobe inputs are clean one-cycle levels sampled at the rising edge. They also assume that a processor held by stall_o does not rely on writes to the data register taking effect in the same cycle as a read strobe. The bench changes inputs only on falling edges. It pulses each strobe for exactly one cycle, and it writes the data register only when no read strobe is pending. Strobes and power-down changes during a busy write are applied on purpose, to exercise the paths that must ignore them or hold through them.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } nvm_op_e;
endpackage

// File: rtl/nvm_down_counter.sv
module nvm_down_counter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         nz_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o = cnt_q;
  assign nz_o  = (cnt_q != '0);
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  // no reset: contents survive rst_ni
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/nvm_pwr_keep.sv
module nvm_pwr_keep (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_req_i,
  input  logic busy_i,
  input  logic stall_i,
  output logic clk_req_o
);
  logic hold_q;

  // a write that overlapped power-down leaves the oscillator running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= 1'b0;
    else if (!pd_req_i) hold_q <= 1'b0;
    else if (busy_i)    hold_q <= 1'b1;
  end

  assign clk_req_o = !pd_req_i || busy_i || stall_i || hold_q;
endmodule

// File: rtl/nvm_byte_ctrl.sv
module nvm_byte_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int RD_STALL     = 4,
  parameter int WR_STALL     = 2,
  parameter int WRITE_CYCLES = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_req_i,
  input  logic              wr_req_i,
  input  logic              pd_req_i,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output logic              stall_o,
  output logic              clk_req_o
);
  localparam int STALL_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int SW        = $clog2(STALL_MAX + 1);
  localparam int TW        = $clog2(WRITE_CYCLES + 1);

  logic [ADDR_W-1:0] addr_q, wr_addr_q;
  logic [DATA_W-1:0] data_q, wr_data_q, rdata;
  logic [SW-1:0]     stall_cnt, stall_ld_val;
  logic [TW-1:0]     tmr_cnt;
  logic              stall_act, busy_act, idle, commit;
  nvm_op_e           op;

  assign idle = !busy_act && !stall_act;

  always_comb begin
    op = OP_NONE;
    if (idle && wr_req_i)      op = OP_WRITE;
    else if (idle && rd_req_i) op = OP_READ;
  end

  assign stall_ld_val = (op == OP_WRITE) ? SW'(WR_STALL) : SW'(RD_STALL);
  assign commit       = (tmr_cnt == TW'(1));

  nvm_down_counter #(.W(SW)) u_stall (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (op != OP_NONE),
    .load_val_i (stall_ld_val),
    .cnt_o      (stall_cnt),
    .nz_o       (stall_act)
  );

  nvm_down_counter #(.W(TW)) u_wtimer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (op == OP_WRITE),
    .load_val_i (TW'(WRITE_CYCLES)),
    .cnt_o      (tmr_cnt),
    .nz_o       (busy_act)
  );

  nvm_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (commit),
    .waddr_i (wr_addr_q),
    .wdata_i (wr_data_q),
    .raddr_i (addr_q),
    .rdata_o (rdata)
  );

  nvm_pwr_keep u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pd_req_i  (pd_req_i),
    .busy_i    (busy_act),
    .stall_i   (stall_act),
    .clk_req_o (clk_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (addr_we_i) addr_q <= addr_i;
  end

  // read result wins over a register load in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              data_q <= '0;
    else if (op == OP_READ)   data_q <= rdata;
    else if (data_we_i)       data_q <= data_i;
  end

  // snapshot for the self-timed write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (op == OP_WRITE) begin
      wr_addr_q <= addr_q;
      wr_data_q <= data_q;
    end
  end

  assign data_o  = data_q;
  assign busy_o  = busy_act;
  assign stall_o = stall_act;

  logic unused_cnt;
  assign unused_cnt = ^stall_cnt;
endmodule

// File: rtl/nvm_byte_ctrl_chk.sv
module nvm_byte_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              data_we_i,
  input logic              rd_req_i,
  input logic              wr_req_i,
  input logic              pd_req_i,
  input logic [DATA_W-1:0] data_o,
  input logic              busy_o,
  input logic              stall_o,
  input logic              clk_req_o
);
  AST_RD_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !wr_req_i && !busy_o && !stall_o) |=> (stall_o && !busy_o)); // R2
  AST_WR_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && !busy_o && !stall_o) |=> (stall_o && busy_o)); // R4
  AST_BUSY_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !data_we_i) |=> $stable(data_o)); // R6
  AST_BUSY_CLK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> clk_req_o); // R9
  AST_NO_PD_CLK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_req_i |-> clk_req_o); // R8
  AST_HOLD_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && pd_req_i) |=> (clk_req_o || !pd_req_i)); // R10
endmodule

bind nvm_byte_ctrl nvm_byte_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_we_i (data_we_i),
  .rd_req_i  (rd_req_i),
  .wr_req_i  (wr_req_i),
  .pd_req_i  (pd_req_i),
  .data_o    (data_o),
  .busy_o    (busy_o),
  .stall_o   (stall_o),
  .clk_req_o (clk_req_o)
);

// File: tb/nvm_byte_ctrl_tb_top.sv
module nvm_byte_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int DW  = 8;
  localparam int RDS = 4;
  localparam int WRS = 2;
  localparam int WC  = 16;
  localparam int WATCHDOG_CYCLES = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_we = 1'b0, data_we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          rd_req = 1'b0, wr_req = 1'b0, pd_req = 1'b0;
  logic [DW-1:0] data_o;
  logic          busy_o, stall_o, clk_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_byte_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .RD_STALL(RDS), .WR_STALL(WRS), .WRITE_CYCLES(WC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_we_i(addr_we), .addr_i(addr),
    .data_we_i(data_we), .data_i(data), .rd_req_i(rd_req), .wr_req_i(wr_req),
    .pd_req_i(pd_req), .data_o(data_o), .busy_o(busy_o), .stall_o(stall_o),
    .clk_req_o(clk_req_o)
  );

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'((a * 37 + (a >> 5) + salt) ^ 8'hA5);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic set_regs(int a, logic [DW-1:0] d);
    addr_we = 1'b1; data_we = 1'b1; addr = AW'(a); data = d;
    @(negedge clk);
    addr_we = 1'b0; data_we = 1'b0;
  endtask

  task automatic set_addr(int a);
    addr_we = 1'b1; addr = AW'(a);
    @(negedge clk);
    addr_we = 1'b0;
  endtask

  task automatic pulse(logic rd, logic wr);
    rd_req = rd; wr_req = wr;
    @(negedge clk);
    rd_req = 1'b0; wr_req = 1'b0;
  endtask

  task automatic count_high(output int s, output int b);
    s = 0; b = 0;
    for (int k = 0; k < 64; k++) begin
      if (stall_o) s++;
      if (busy_o) b++;
      if (!stall_o && !busy_o) break;
      @(negedge clk);
    end
  endtask

  task automatic do_write(int a, logic [DW-1:0] d, bit check_timing);
    int s, b;
    set_regs(a, d);
    pulse(1'b0, 1'b1);
    count_high(s, b);
    if (check_timing) begin
      chk("R3 write stall cycles", s, WRS);
      chk("R4 busy cycles", b, WC);
    end
  endtask

  task automatic do_read(int a, logic [DW-1:0] exp, string req);
    int s, b;
    set_addr(a);
    pulse(1'b1, 1'b0);
    count_high(s, b);
    chk("R2 read stall cycles", s, RDS);
    chk(req, int'(data_o), int'(exp));
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int s, b;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 stall", stall_o, 0);
    chk("R1 data", int'(data_o), 0);
    chk("R1 clk_req", clk_req_o, 1);

    // R12 sweep every location, R4 timing, R2 readback
    for (int a = 0; a < (1 << AW); a++) do_write(a, pat(a, 0), a < 8 || a >= (1 << AW) - 8);
    for (int a = 0; a < (1 << AW); a++) do_read(a, pat(a, 0), "R12 sweep readback");

    // R5 / R6 activity during a busy write
    do_write(10, 8'h3C, 1'b0);
    set_regs(10, 8'h3C);
    pulse(1'b0, 1'b1);            // N1
    set_regs(20, 8'hC3);          // N2, R5 register change
    chk("R5 data reg readable while busy", int'(data_o), 8'hC3);
    pulse(1'b1, 1'b0);            // N3
    chk("R6 read while busy no stall", stall_o, 0);
    chk("R6 read while busy keeps data", int'(data_o), 8'hC3);
    pulse(1'b0, 1'b1);            // N4
    chk("R6 write while busy no stall", stall_o, 0);
    count_high(s, b);
    chk("R6 busy not restarted", b, WC - 3);
    do_read(20, pat(20, 0), "R6 ignored write left store");
    do_read(10, 8'h3C, "R5 latched values written");

    // R7 simultaneous strobes
    set_regs(40, 8'h5E);
    pulse(1'b1, 1'b1);
    count_high(s, b);
    chk("R7 write stall wins", s, WRS);
    chk("R7 write busy", b, WC);
    chk("R7 data keeps write value", int'(data_o), 8'h5E);
    do_read(40, 8'h5E, "R7 write committed");

    // R9 / R10 power-down during write
    set_regs(30, 8'h77);
    pulse(1'b0, 1'b1);            // N1
    pd_req = 1'b1;
    @(negedge clk);               // N2
    b = 0;
    for (int k = 0; k < 64 && busy_o; k++) begin
      b++;
      chk("R9 clk_req while busy", clk_req_o, 1);
      @(negedge clk);
    end
    chk("R9 write ran through power-down", b, WC - 1);
    chk("R10 clk_req held after write", clk_req_o, 1);
    repeat (3) @(negedge clk);
    chk("R10 clk_req still held", clk_req_o, 1);
    pd_req = 1'b0;
    @(negedge clk);
    chk("R8 clk_req with pd low", clk_req_o, 1);
    pd_req = 1'b1;
    #1;
    chk("R8 clk_req off when idle", clk_req_o, 0);
    @(negedge clk);
    chk("R8 clk_req stays off", clk_req_o, 0);
    pd_req = 1'b0;
    @(negedge clk);
    do_read(30, 8'h77, "R9 write committed under power-down");

    // R11 reset keeps store
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 data after second reset", int'(data_o), 0);
    do_read(100, pat(100, 0), "R11 contents kept over reset");
    do_read((1 << AW) - 1, pat((1 << AW) - 1, 0), "R11 top location kept");

    finish_up();
  end
endmodule